// File: doc/BRIEF.md
# Stereo Mix Pixel Selector

The block builds one stereo pixel stream out of two eye streams. Every input beat carries a left-eye (top) pixel and a right-eye (bottom) pixel, plus the horizontal and vertical position of that pixel. A subsampling pattern and a one-bit polarity decide, pixel by pixel, which eye is forwarded. The pattern can be line-interleaved, column-interleaved or checkerboard. The polarity register can flip at every frame start or every field start. A one-shot forced polarity can also decide which eye comes first in the next frame or field.

The data path is a valid/ready stream that the block does not buffer. `out_valid` follows `in_valid` and `in_ready` follows `out_ready`, both combinationally. The selected pixel depends only on the current beat and on the polarity register. While a beat is held under back-pressure, its output therefore stays the same as long as the beat and the polarity do not change. Polarity changes only on the start pulses, which are plain control inputs. A layer marked as the bottom of a blend chain must not use mixing. If a mixing mode is requested there, the block raises a configuration error and forwards the top stream.

Top module: `stereo_mix_sel`

## Requirements
- R1: `out_valid` equals `in_valid` and `in_ready` equals `out_ready` in every cycle. `out_pix` equals `bot_pix` when `out_sel_bot` is 1 and `top_pix` when it is 0.
- R2: Mode values 0, 1, 3, 5 and 7 are single plane. `out_sel_bot` is 0 and the top pixel is forwarded whatever the position and polarity.
- R3: Mode 2 (rows): `out_sel_bot` = `pix_y[0]` XOR `polarity`. With polarity 0, even lines take the top pixel.
- R4: Mode 4 (columns): `out_sel_bot` = `pix_x[0]` XOR `polarity`.
- R5: Mode 6 (checkerboard): `out_sel_bot` = `pix_x[0]` XOR `pix_y[0]` XOR `polarity`.
- R6: With `frame_alt_en` = 1 and no frame force pending, `polarity` inverts in the cycle after each `frame_start`. With `frame_alt_en` = 0, a `frame_start` alone leaves it unchanged.
- R7: With `field_alt_en` = 1 and no field force pending, `polarity` inverts in the cycle after each `field_start`. With `field_alt_en` = 0, a `field_start` alone leaves it unchanged.
- R8: `polarity` is 0 after reset and changes only in the cycle after a `frame_start` or `field_start`.
- R9: A `force_load` records `force_frame`. Code 2 makes the next frame start with polarity 0 (top first), code 3 with polarity 1, and codes 0 and 1 record no force. The next `frame_start` applies a recorded force in place of alternation and then clears it.
- R10: `force_field` uses the same codes for the next `field_start`. The force is applied once and then cleared.
- R11: When both pulses arrive in one cycle, a pending frame force wins, then a pending field force. With no force pending, both enabled toggles apply, so two toggles cancel. Each pulse clears its own pending force.
- R12: `cfg_err` = `bottom_layer` AND mode in {2,4,6}. While `cfg_err` is 1, the top pixel is forwarded.
- R13: A `force_load` replaces both pending forces. When it coincides with a start pulse, the pulse acts on the forces pending before the load, and the newly loaded forces wait for the next pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted (follows out_ready) |
| top_pix | input | PIX_W | Left-eye pixel |
| bot_pix | input | PIX_W | Right-eye pixel |
| pix_x | input | X_W | Horizontal position of the beat |
| pix_y | input | Y_W | Vertical position of the beat |
| out_valid | output | 1 | Output beat valid (follows in_valid) |
| out_ready | input | 1 | Downstream ready |
| out_pix | output | PIX_W | Selected pixel |
| out_sel_bot | output | 1 | 1 when the bottom-eye pixel is selected |
| mode | input | 3 | Subsampling mode: 2 rows, 4 columns, 6 checkerboard, others single plane |
| frame_alt_en | input | 1 | Invert polarity at each frame start |
| field_alt_en | input | 1 | Invert polarity at each field start |
| frame_start | input | 1 | Frame start pulse |
| field_start | input | 1 | Field start pulse |
| force_load | input | 1 | Record force_frame and force_field |
| force_frame | input | 2 | Next-frame polarity force: 0 none, 2 top, 3 bottom |
| force_field | input | 2 | Next-field polarity force: 0 none, 2 top, 3 bottom |
| bottom_layer | input | 1 | This layer is the bottom of its blend chain |
| polarity | output | 1 | Current selection polarity |
| cfg_err | output | 1 | Mixing requested on a bottom layer |

## Verification
Every mode value is driven with random positions at both polarities. The odd codes show whether the decode treats them as single plane. Rows, columns and checkerboard are told apart because each responds to a different position bit. Directed pulse trains separate frame alternation from field alternation and show that a force applies exactly once. Coincident frame and field pulses, with and without pending forces, fix the priority order. A force load landing on a start pulse tells apart designs that apply the new force at once from ones that defer it. A long random run with toggling back-pressure and bottom-layer flags compares every output on every cycle.

// File: rtl/smx_pkg.sv
package smx_pkg;

  typedef enum logic [2:0] {
    MIX_SINGLE = 3'd0,
    MIX_ROWS   = 3'd2,
    MIX_COLS   = 3'd4,
    MIX_CHECK  = 3'd6
  } mix_mode_e;

  // force code: bit 1 = force requested, bit 0 = polarity to start with
  localparam logic [1:0] FORCE_NONE = 2'd0;
  localparam logic [1:0] FORCE_TOP  = 2'd2;
  localparam logic [1:0] FORCE_BOT  = 2'd3;

  localparam int unsigned SLOT_FRAME = 0;
  localparam int unsigned SLOT_FIELD = 1;
  localparam int unsigned NUM_SLOTS  = 2;

  function automatic logic is_mixing(input logic [2:0] m);
    return (m == MIX_ROWS) || (m == MIX_COLS) || (m == MIX_CHECK);
  endfunction

endpackage

// File: rtl/smx_force_slot.sv
module smx_force_slot (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [1:0] code,
  input  logic       start,
  output logic       pend_v,
  output logic       pend_val
);
  // A load replaces the request; a start consumes a request that was there before it.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v   <= 1'b0;
      pend_val <= 1'b0;
    end else if (load) begin
      pend_v   <= code[1];
      pend_val <= code[0];
    end else if (start) begin
      pend_v   <= 1'b0;
    end
  end
endmodule

// File: rtl/smx_polarity.sv
module smx_polarity
  import smx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_start,
  input  logic       field_start,
  input  logic       frame_alt_en,
  input  logic       field_alt_en,
  input  logic       force_load,
  input  logic [1:0] force_frame,
  input  logic [1:0] force_field,
  output logic       polarity
);
  logic [NUM_SLOTS-1:0]      starts;
  logic [NUM_SLOTS-1:0][1:0] codes;
  logic [NUM_SLOTS-1:0]      pv;
  logic [NUM_SLOTS-1:0]      pval;
  logic                      pol_q;
  logic                      pol_d;
  logic                      flip;

  assign starts[SLOT_FRAME] = frame_start;
  assign starts[SLOT_FIELD] = field_start;
  assign codes[SLOT_FRAME]  = force_frame;
  assign codes[SLOT_FIELD]  = force_field;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    smx_force_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (force_load),
      .code     (codes[s]),
      .start    (starts[s]),
      .pend_v   (pv[s]),
      .pend_val (pval[s])
    );
  end

  assign flip = (frame_start & frame_alt_en) ^ (field_start & field_alt_en);

  always_comb begin
    if (frame_start && pv[SLOT_FRAME])      pol_d = pval[SLOT_FRAME];
    else if (field_start && pv[SLOT_FIELD]) pol_d = pval[SLOT_FIELD];
    else                                    pol_d = pol_q ^ flip;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pol_q <= 1'b0;
    else        pol_q <= pol_d;
  end

  assign polarity = pol_q;
endmodule

// File: rtl/smx_pattern.sv
module smx_pattern
  import smx_pkg::*;
(
  input  logic [2:0] mode,
  input  logic       x0,
  input  logic       y0,
  input  logic       pol,
  input  logic       bottom_layer,
  output logic       sel_bot,
  output logic       cfg_err
);
  logic raw;

  always_comb begin
    unique case (mode)
      MIX_ROWS:  raw = y0 ^ pol;
      MIX_COLS:  raw = x0 ^ pol;
      MIX_CHECK: raw = x0 ^ y0 ^ pol;
      default:   raw = 1'b0;
    endcase
  end

  assign cfg_err = bottom_layer & is_mixing(mode);
  assign sel_bot = raw & ~cfg_err;
endmodule

// File: rtl/stereo_mix_sel.sv
module stereo_mix_sel #(
  parameter int unsigned PIX_W = 24,
  parameter int unsigned X_W   = 13,
  parameter int unsigned Y_W   = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] top_pix,
  input  logic [PIX_W-1:0] bot_pix,
  input  logic [X_W-1:0]   pix_x,
  input  logic [Y_W-1:0]   pix_y,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PIX_W-1:0] out_pix,
  output logic             out_sel_bot,
  input  logic [2:0]       mode,
  input  logic             frame_alt_en,
  input  logic             field_alt_en,
  input  logic             frame_start,
  input  logic             field_start,
  input  logic             force_load,
  input  logic [1:0]       force_frame,
  input  logic [1:0]       force_field,
  input  logic             bottom_layer,
  output logic             polarity,
  output logic             cfg_err
);
  logic pol;
  logic sel;
  // only the parity bit of each position counter takes part in selection
  logic unused_pos;
  assign unused_pos = ^{pix_x[X_W-1:1], pix_y[Y_W-1:1]};

  smx_polarity u_pol (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_start  (frame_start),
    .field_start  (field_start),
    .frame_alt_en (frame_alt_en),
    .field_alt_en (field_alt_en),
    .force_load   (force_load),
    .force_frame  (force_frame),
    .force_field  (force_field),
    .polarity     (pol)
  );

  smx_pattern u_pat (
    .mode         (mode),
    .x0           (pix_x[0]),
    .y0           (pix_y[0]),
    .pol          (pol),
    .bottom_layer (bottom_layer),
    .sel_bot      (sel),
    .cfg_err      (cfg_err)
  );

  assign out_valid   = in_valid;
  assign in_ready    = out_ready;
  assign out_pix     = sel ? bot_pix : top_pix;
  assign out_sel_bot = sel;
  assign polarity    = pol;
endmodule

// File: rtl/stereo_mix_sel_checker.sv
module stereo_mix_sel_checker #(
  parameter int unsigned PIX_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [PIX_W-1:0] top_pix,
  input logic [PIX_W-1:0] bot_pix,
  input logic [PIX_W-1:0] out_pix,
  input logic             out_sel_bot,
  input logic [2:0]       mode,
  input logic             y0,
  input logic             frame_start,
  input logic             field_start,
  input logic             bottom_layer,
  input logic             polarity,
  input logic             cfg_err
);
  logic mixing;
  assign mixing = (mode == 3'd2) || (mode == 3'd4) || (mode == 3'd6);

  AST_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid == in_valid) && (in_ready == out_ready)); // R1
  AST_PIX_FOLLOWS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    out_pix == (out_sel_bot ? bot_pix : top_pix)); // R1
  AST_SINGLE_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    !mixing |-> !out_sel_bot); // R2
  AST_ROW_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd2 && !bottom_layer) |-> (out_sel_bot == (y0 ^ polarity))); // R3
  AST_POL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_start || field_start) |=> $stable(polarity)); // R8
  AST_BOTTOM_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (bottom_layer && mixing) |-> (cfg_err && !out_sel_bot)); // R12
endmodule

bind stereo_mix_sel stereo_mix_sel_checker #(.PIX_W(PIX_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .top_pix      (top_pix),
  .bot_pix      (bot_pix),
  .out_pix      (out_pix),
  .out_sel_bot  (out_sel_bot),
  .mode         (mode),
  .y0           (pix_y[0]),
  .frame_start  (frame_start),
  .field_start  (field_start),
  .bottom_layer (bottom_layer),
  .polarity     (polarity),
  .cfg_err      (cfg_err)
);

// File: tb/stereo_mix_sel_bench.sv
module stereo_mix_sel_bench;
  localparam int PERIOD = 10;
  localparam int PW = 24;
  localparam int XW = 13;
  localparam int YW = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 0, out_ready = 0;
  logic [PW-1:0] top_pix = '0, bot_pix = '0;
  logic [XW-1:0] pix_x = '0;
  logic [YW-1:0] pix_y = '0;
  logic [2:0] mode = 3'd0;
  logic frame_alt_en = 0, field_alt_en = 0, frame_start = 0, field_start = 0;
  logic force_load = 0, bottom_layer = 0;
  logic [1:0] force_frame = 2'd0, force_field = 2'd0;
  logic in_ready, out_valid, out_sel_bot, polarity, cfg_err;
  logic [PW-1:0] out_pix;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // reference state: -1 means no force pending
  int m_pol = 0;
  int m_pf = -1;
  int m_pd = -1;

  always #(PERIOD/2) clk = ~clk;

  stereo_mix_sel u_stereo_mix_sel (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .top_pix(top_pix), .bot_pix(bot_pix), .pix_x(pix_x), .pix_y(pix_y),
    .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix),
    .out_sel_bot(out_sel_bot), .mode(mode), .frame_alt_en(frame_alt_en),
    .field_alt_en(field_alt_en), .frame_start(frame_start),
    .field_start(field_start), .force_load(force_load),
    .force_frame(force_frame), .force_field(force_field),
    .bottom_layer(bottom_layer), .polarity(polarity), .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int code_to_pend(input logic [1:0] c);
    if (c == 2'd2) return 0;
    if (c == 2'd3) return 1;
    return -1;
  endfunction

  // compare outputs in the middle of the low phase, then advance the model at the edge
  task automatic step(input string ptag);
    int exp_sel;
    bit mix;
    bit err;
    string st;
    #(PERIOD/4);
    mix = (mode == 2 || mode == 4 || mode == 6);
    err = bottom_layer && mix;
    case (mode)
      3'd2: begin exp_sel = pix_y[0] ^ m_pol; st = "R3"; end
      3'd4: begin exp_sel = pix_x[0] ^ m_pol; st = "R4"; end
      3'd6: begin exp_sel = pix_x[0] ^ pix_y[0] ^ m_pol; st = "R5"; end
      default: begin exp_sel = 0; st = "R2"; end
    endcase
    if (err) begin exp_sel = 0; st = "R12"; end
    chk(out_valid == in_valid && in_ready == out_ready, "R1",
        {out_valid, in_ready}, {in_valid, out_ready});
    chk(out_sel_bot == exp_sel[0], st, out_sel_bot, exp_sel);
    chk(out_pix == (exp_sel != 0 ? bot_pix : top_pix), "R1", out_pix,
        exp_sel != 0 ? bot_pix : top_pix);
    chk(cfg_err == err, "R12", cfg_err, err);
    chk(polarity == m_pol[0], ptag, polarity, m_pol);
    @(posedge clk);
    if (frame_start && m_pf >= 0)      m_pol = m_pf;
    else if (field_start && m_pd >= 0) m_pol = m_pd;
    else m_pol = m_pol ^ ((frame_start & frame_alt_en) ^ (field_start & field_alt_en));
    if (force_load) begin
      m_pf = code_to_pend(force_frame);
      m_pd = code_to_pend(force_field);
    end else begin
      if (frame_start) m_pf = -1;
      if (field_start) m_pd = -1;
    end
    @(negedge clk);
    frame_start = 0; field_start = 0; force_load = 0;
  endtask

  task automatic rand_beat();
    top_pix = PW'($urandom); bot_pix = PW'($urandom);
    pix_x = XW'($urandom); pix_y = YW'($urandom);
    in_valid = 1'($urandom); out_ready = 1'($urandom);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(polarity == 1'b0, "R8", polarity, 0);
    chk(cfg_err == 1'b0, "R12", cfg_err, 0);
    rst_n = 1;

    // every mode code, both polarities reached later by alternation
    for (int m = 0; m < 8; m++) begin
      mode = 3'(m);
      for (int i = 0; i < 16; i++) begin rand_beat(); step("R8"); end
    end

    // R6 frame alternation in row mode
    mode = 3'd2; frame_alt_en = 1;
    for (int i = 0; i < 6; i++) begin
      rand_beat(); frame_start = (i % 2 == 0); step("R6");
    end
    frame_alt_en = 0; frame_start = 1; rand_beat(); step("R6");
    rand_beat(); step("R6");

    // R7 field alternation in column mode
    mode = 3'd4; field_alt_en = 1;
    for (int i = 0; i < 6; i++) begin
      rand_beat(); field_start = (i % 3 == 0); step("R7");
    end
    field_alt_en = 0; field_start = 1; rand_beat(); step("R7");
    rand_beat(); step("R7");

    // R9 frame force, overriding alternation, once only
    mode = 3'd6; frame_alt_en = 1;
    force_load = 1; force_frame = 2'd3; force_field = 2'd0; rand_beat(); step("R9");
    for (int i = 0; i < 3; i++) begin rand_beat(); step("R9"); end
    frame_start = 1; rand_beat(); step("R9");
    frame_start = 1; rand_beat(); step("R9");
    force_load = 1; force_frame = 2'd2; rand_beat(); step("R9");
    frame_start = 1; rand_beat(); step("R9");
    force_load = 1; force_frame = 2'd1; rand_beat(); step("R9");
    frame_start = 1; rand_beat(); step("R9");
    rand_beat(); step("R9");
    frame_alt_en = 0;

    // R10 field force
    field_alt_en = 1;
    force_load = 1; force_frame = 2'd0; force_field = 2'd3; rand_beat(); step("R10");
    field_start = 1; rand_beat(); step("R10");
    field_start = 1; rand_beat(); step("R10");
    force_load = 1; force_field = 2'd2; rand_beat(); step("R10");
    field_start = 1; rand_beat(); step("R10");
    rand_beat(); step("R10");

    // R11 coincident pulses
    frame_alt_en = 1; field_alt_en = 1;
    frame_start = 1; field_start = 1; rand_beat(); step("R11");
    force_load = 1; force_frame = 2'd3; force_field = 2'd2; rand_beat(); step("R11");
    frame_start = 1; field_start = 1; rand_beat(); step("R11");
    force_load = 1; force_frame = 2'd0; force_field = 2'd2; rand_beat(); step("R11");
    frame_start = 1; field_start = 1; rand_beat(); step("R11");
    frame_start = 1; rand_beat(); step("R11");

    // R13 load coinciding with a start pulse
    force_load = 1; force_frame = 2'd3; force_field = 2'd3; frame_start = 1;
    rand_beat(); step("R13");
    rand_beat(); step("R13");
    frame_start = 1; rand_beat(); step("R13");
    field_start = 1; rand_beat(); step("R13");
    rand_beat(); step("R13");

    // R12 bottom layer with every mode
    bottom_layer = 1;
    for (int m = 0; m < 8; m++) begin mode = 3'(m); rand_beat(); step("R12"); end
    bottom_layer = 0;

    // long random mix
    for (int i = 0; i < 3000; i++) begin
      rand_beat();
      mode = 3'($urandom);
      bottom_layer = ($urandom % 8 == 0);
      frame_alt_en = 1'($urandom); field_alt_en = 1'($urandom);
      frame_start = ($urandom % 6 == 0); field_start = ($urandom % 4 == 0);
      force_load = ($urandom % 7 == 0);
      force_frame = 2'($urandom); force_field = 2'($urandom);
      step("R11");
    end

    done = 1;
    finish_run();
  end
endmodule